// File: doc/BRIEF.md
# Frame Clock Timing Monitor

This block watches the word-select (frame) clock of an audio serial port, sampled on the port's own bit clock. It measures every high and every low frame-clock phase in bit-clock periods. It compares each measurement with the length that software has programmed: a frame period value and a high-time value. A phase that ends too soon is reported as early, and one that runs too long is reported as late. A frame clock that stays at one level for more than twice the programmed period is reported as missing.

The block also takes a flag from the data path that signals a buffer request overload. All five conditions land in sticky status bits. A single read strobe clears every bit, and each bit has a mask bit that keeps it off the interrupt output. Early and missing-clock reports are rate limited. After one of them is reported, no further report of that kind is made until the frame clock has run one full, exactly timed period.

Top module: `lrck_timing_monitor`

## Requirements
- R1: While and just after reset, `status_o` is 0 and `irq_o` is 0.
- R2: Every status bit is sticky. It holds until a cycle with `rd_i` high, which clears it. A bit whose set condition occurs in the same cycle as `rd_i` ends up set.
- R3: `irq_o` is high exactly when some status bit is set and its `mask_i` bit (same position) is 0. A mask bit of 1 blocks that status bit.
- R4: Early is bit 1. It sets when a completed phase is shorter than expected. The expected length of a high phase is `high_i`, and the expected length of a low phase is `period_i - high_i`. Length is counted in clock cycles at the sampled `lrck_i` level.
- R5: Late is bit 2. It sets when a completed phase is longer than expected. Late reports are never suppressed.
- R6: Error is bit 3. It sets whenever an early or late report is made.
- R7: No-clock is bit 4. It sets in the cycle in which `lrck_i` has held one level for 2*`period_i`+1 consecutive cycles.
- R8: After an early report, further early events are ignored. After a no-clock report, further no-clock events are ignored. Reporting of both resumes once two consecutive completed phases have both matched their expected lengths exactly.
- R9: Overload is bit 0. It sets in any cycle with `ovfl_req_i` high.
- R10: The phase that is in progress when the first `lrck_i` transition after reset occurs is not judged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lrck_i | input | 1 | Frame clock, sampled on clk_i |
| period_i | input | CNT_W | Expected frame period in bit clocks |
| high_i | input | CNT_W | Expected high-phase length in bit clocks |
| ovfl_req_i | input | 1 | Buffer request overload flag |
| rd_i | input | 1 | Status read strobe; clears all bits |
| mask_i | input | 5 | Per-bit interrupt mask, 1 = masked |
| status_o | output | 5 | Sticky status: {noclk, error, late, early, ovfl} |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is the re-arming of suppressed early and no-clock reports. It needs a report, then a second event of the same kind that must stay silent, then two consecutive exactly timed phases, and then a third event that must be reported again. The stimulus builds the frame clock phase by phase with chosen lengths. It interleaves reads in the middle of phases, so that a read never lengthens a phase. It also holds one level for exactly 2P and then 2P+1 cycles, which places the no-clock threshold on a known cycle.

// File: rtl/lrck_mon_pkg.sv
package lrck_mon_pkg;
  localparam int unsigned NSTAT     = 5;
  localparam int unsigned IDX_OVFL  = 0;
  localparam int unsigned IDX_EARLY = 1;
  localparam int unsigned IDX_LATE  = 2;
  localparam int unsigned IDX_ERR   = 3;
  localparam int unsigned IDX_NOCLK = 4;
  typedef logic [NSTAT-1:0] stat_t;
endpackage

// File: rtl/lrck_phase_counter.sv
module lrck_phase_counter #(
  parameter int unsigned CNT_W = 10,
  localparam int unsigned CW = CNT_W + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lrck_i,
  output logic          edge_o,
  output logic          lvl_o,
  output logic [CW-1:0] len_o,
  output logic [CW-1:0] cnt_o,
  output logic          synced_o
);
  logic          lvl_q, synced_q;
  logic [CW-1:0] cnt_q;

  assign edge_o   = lrck_i != lvl_q;
  assign lvl_o    = lvl_q;
  assign len_o    = cnt_q;
  assign cnt_o    = cnt_q;
  assign synced_o = synced_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q    <= 1'b0;
      cnt_q    <= '0;
      synced_q <= 1'b0;
    end else if (edge_o) begin
      lvl_q    <= lrck_i;
      cnt_q    <= CW'(1);
      synced_q <= 1'b1;
    end else if (cnt_q != '1) begin
      cnt_q <= cnt_q + CW'(1);  // saturate on a dead clock
    end
  end

  p_len_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o && synced_q) |-> (len_o != '0));
  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> (cnt_q == CW'(1)));
endmodule

// File: rtl/lrck_phase_judge.sv
module lrck_phase_judge #(
  parameter int unsigned CNT_W = 10,
  localparam int unsigned CW = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic             lvl_i,
  input  logic [CW-1:0]    len_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic             synced_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] high_i,
  output logic             early_o,
  output logic             late_o,
  output logic             noclk_o
);
  logic          early_arm_q, noclk_arm_q, good_q;
  logic [CW-1:0] exp_len;
  logic          judge, match, early_raw, noclk_raw;

  always_comb begin
    exp_len   = lvl_i ? {1'b0, high_i} : {1'b0, period_i - high_i};
    judge     = edge_i && synced_i;
    match     = judge && (len_i == exp_len);
    early_raw = judge && (len_i < exp_len);
    noclk_raw = !edge_i && (cnt_i == {period_i, 1'b0});
  end

  assign early_o = early_raw && early_arm_q;
  assign late_o  = judge && (len_i > exp_len);
  assign noclk_o = noclk_raw && noclk_arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      early_arm_q <= 1'b1;
      noclk_arm_q <= 1'b1;
      good_q      <= 1'b0;
    end else begin
      if (early_o) early_arm_q <= 1'b0;
      if (noclk_o) noclk_arm_q <= 1'b0;
      if (noclk_raw) good_q <= 1'b0;
      else if (judge) good_q <= match;
      if (match && good_q) begin  // one full period on time
        early_arm_q <= 1'b1;
        noclk_arm_q <= 1'b1;
      end
    end
  end

  p_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(early_o && late_o));
  p_noclk_disarm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    noclk_o |=> !noclk_arm_q);
  p_rearm_on_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(early_arm_q) |-> $past(edge_i));
endmodule

// File: rtl/lrck_status_regs.sv
module lrck_status_regs
  import lrck_mon_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  stat_t set_i,
  input  logic  rd_i,
  input  stat_t mask_i,
  output stat_t status_o,
  output logic  irq_o
);
  stat_t status_q;

  for (genvar k = 0; k < NSTAT; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        status_q[k] <= 1'b0;
      else if (set_i[k])  status_q[k] <= 1'b1;  // set beats read
      else if (rd_i)      status_q[k] <= 1'b0;
    end
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & ~mask_i);

  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> ((status_q & $past(status_q)) == $past(status_q)));
  p_set_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/lrck_timing_monitor.sv
module lrck_timing_monitor
  import lrck_mon_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lrck_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] high_i,
  input  logic             ovfl_req_i,
  input  logic             rd_i,
  input  logic [4:0]       mask_i,
  output logic [4:0]       status_o,
  output logic             irq_o
);
  localparam int unsigned CW = CNT_W + 1;

  logic          edge_w, lvl_w, synced_w;
  logic [CW-1:0] len_w, cnt_w;
  logic          early_w, late_w, noclk_w;
  stat_t         set_w;

  lrck_phase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .lrck_i,
    .edge_o(edge_w), .lvl_o(lvl_w), .len_o(len_w), .cnt_o(cnt_w),
    .synced_o(synced_w)
  );

  lrck_phase_judge #(.CNT_W(CNT_W)) u_judge (
    .clk_i, .rst_ni,
    .edge_i(edge_w), .lvl_i(lvl_w), .len_i(len_w), .cnt_i(cnt_w),
    .synced_i(synced_w), .period_i, .high_i,
    .early_o(early_w), .late_o(late_w), .noclk_o(noclk_w)
  );

  always_comb begin
    set_w            = '0;
    set_w[IDX_OVFL]  = ovfl_req_i;
    set_w[IDX_EARLY] = early_w;
    set_w[IDX_LATE]  = late_w;
    set_w[IDX_ERR]   = early_w || late_w;
    set_w[IDX_NOCLK] = noclk_w;
  end

  lrck_status_regs u_stat (
    .clk_i, .rst_ni, .set_i(set_w), .rd_i, .mask_i,
    .status_o, .irq_o
  );

  p_irq_unmasked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[IDX_EARLY] && !mask_i[IDX_EARLY]) |-> irq_o);
  p_err_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (early_w || late_w) |=> status_o[IDX_ERR]);
endmodule

// File: tb/lrck_timing_monitor_bench.sv
module lrck_timing_monitor_bench;
  localparam int CNT_W = 10;
  localparam int CMAX  = (1 << (CNT_W + 1)) - 1;

  logic clk = 1'b0, rst_ni = 1'b0, lrck = 1'b0, ovfl = 1'b0, rd = 1'b0;
  logic [CNT_W-1:0] period = 16, high = 8;
  logic [4:0] mask = '0, status;
  logic irq;
  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  // behavioural reference state
  int m_lvl, m_cnt, m_good;
  bit m_sync, m_earm, m_narm;
  bit [4:0] m_st;

  always #4 clk = ~clk;

  lrck_timing_monitor #(.CNT_W(CNT_W)) u_lrck_timing_monitor (
    .clk_i(clk), .rst_ni, .lrck_i(lrck), .period_i(period), .high_i(high),
    .ovfl_req_i(ovfl), .rd_i(rd), .mask_i(mask), .status_o(status), .irq_o(irq)
  );

  function automatic string tag_of(int b);
    case (b)
      0: return "R9"; 1: return "R4"; 2: return "R5"; 3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    for (int b = 0; b < 5; b++) chk(status[b], m_st[b], tag_of(b));
    chk(irq, |(m_st & ~mask), "R3");
  endtask

  task automatic model_reset();
    m_lvl = 0; m_cnt = 0; m_good = 0; m_sync = 0; m_earm = 1; m_narm = 1; m_st = '0;
  endtask

  task automatic model_step();
    bit e = 0, l = 0, n = 0, match = 0;
    int exp;
    if (int'(lrck) != m_lvl) begin
      if (m_sync) begin
        exp = m_lvl ? int'(high) : int'(period) - int'(high);
        match = (m_cnt == exp);
        if (m_cnt < exp && m_earm) begin e = 1; m_earm = 0; end
        l = (m_cnt > exp);
        if (match && m_good == 1) begin m_earm = 1; m_narm = 1; end
        m_good = match ? 1 : 0;
      end
      m_cnt = 1; m_lvl = int'(lrck); m_sync = 1;
    end else begin
      if (m_cnt == 2 * int'(period)) begin
        m_good = 0;
        if (m_narm) begin n = 1; m_narm = 0; end
      end
      if (m_cnt < CMAX) m_cnt++;
    end
    if (rd) m_st = '0;
    m_st |= {n, e | l, l, e, ovfl};
  endtask

  task automatic step(input logic l, input logic ov, input logic r);
    lrck = l; ovfl = ov; rd = r;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    ovfl = 0; rd = 0;
  endtask

  task automatic phase(input logic l, input int n, input int rd_at);
    for (int i = 0; i < n; i++) step(l, 1'b0, logic'(i == rd_at));
  endtask

  task automatic do_reset();
    rst_ni = 0; lrck = 0; model_reset();
    @(negedge clk); @(negedge clk);
    chk(status, 0, "R1"); chk(irq, 0, "R1");
    rst_ni = 1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog R1 actual=%0d expected=0", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // sync and run clean frames, P=16 H=8
    phase(0, 4, -1); phase(1, 8, -1); phase(0, 8, -1); phase(1, 8, -1); phase(0, 8, -1);
    chk(status, 0, "R10");
    // short high -> early + error
    phase(1, 5, -1); phase(0, 8, -1);
    chk(status[1], 1, "R4"); chk(status[3], 1, "R6"); chk(irq, 1, "R3");
    // second short high suppressed
    phase(1, 5, 2);
    chk(status, 0, "R2");
    phase(0, 8, -1);
    chk(status[1], 0, "R8"); chk(status[3], 0, "R8");
    // one good period re-arms
    phase(1, 8, -1); phase(0, 8, -1); phase(1, 5, -1); phase(0, 8, -1);
    chk(status[1], 1, "R8");
    phase(1, 8, 2);
    // long low -> late, repeats
    phase(0, 11, -1); phase(1, 8, -1);
    chk(status[2], 1, "R5"); chk(status[3], 1, "R6"); chk(status[1], 0, "R5");
    phase(0, 8, 2); phase(1, 12, -1); phase(0, 8, -1);
    chk(status[2], 1, "R5");
    phase(1, 8, 2);
    // asymmetric frame, H=5 low=11
    high = 5;
    phase(0, 11, -1); phase(1, 5, -1); phase(0, 11, -1); phase(1, 5, 3);
    phase(0, 11, -1); phase(1, 5, -1);
    chk(status, 0, "R4");
    phase(0, 7, -1); phase(1, 5, -1);
    chk(status[1], 1, "R4");
    // missing frame clock: threshold at 2P+1
    phase(0, 32, 2);
    chk(status[4], 0, "R7");
    step(0, 0, 0);
    chk(status[4], 1, "R7");
    phase(0, 20, 2);
    chk(status[4], 0, "R8");
    phase(1, 8, -1); phase(0, 40, 2);
    chk(status[4], 0, "R8");
    phase(1, 5, -1); phase(0, 11, -1); phase(1, 5, -1); phase(0, 40, 2);
    chk(status[4], 1, "R8");
    // mask
    mask = 5'b10000; #1;
    chk(irq, 0, "R3");
    mask = 5'b00000; #1;
    chk(irq, 1, "R3");
    // overload, and set in the read cycle
    step(0, 0, 1);
    step(0, 1, 0);
    chk(status[0], 1, "R9");
    step(0, 1, 1);
    chk(status[0], 1, "R2");
    step(0, 0, 1);
    chk(status[0], 0, "R2");
    // first phase after reset is not judged
    do_reset();
    phase(0, 3, -1); phase(1, 3, -1);
    chk(status, 0, "R10");
    phase(0, 8, -1);
    chk(status[1], 1, "R10");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule